// File: doc/BRIEF.md
# Serial Security Unlock Controller

This block guards protected non-volatile memory behind an eight-byte key. After a power-on reset it takes bytes from an upstream serial receiver as a valid/data stream. Each byte is compared, in arrival order, with the stored key bytes, which reach the block on a parallel bus. A sticky mismatch bit records any difference. The outcome is decided only when the eighth byte arrives, so an early mismatch does not cut reception short.

When the eighth byte has been taken, the block sends the transmitter a one-cycle break request, whether or not the key matched. From the next cycle it enables command decoding, and later received bytes pass straight through to the command path. If every byte matched, the block is unlocked until the next power-on reset. Otherwise it stays locked, but command operation still goes on: reads from the protected address window return 8'h00, and instruction fetches from that window raise an illegal-address reset request.

A general reset keeps the unlock flag and the finished key phase. No new key is needed after it. Only a power-on reset clears the flag and the byte counter.

Top module: `sec_unlock_ctrl`

## Requirements
- R1: While `por_n` is low and in the first cycle after it rises, `unlocked`, `brk_req`, `cmd_en` and `cmd_valid` are all 0.
- R2: Key byte i sits at `key_bytes[8*i+7:8*i]`, and byte 0 is compared with the first received byte. `unlocked` is 1 in the cycle after the eighth accepted byte only if all eight bytes matched in order. It is 0 if the same bytes arrive in another order.
- R3: A mismatch at any single position, first, middle or last, leaves `unlocked` at 0. Reception still takes exactly eight bytes before the outcome.
- R4: `brk_req` is high for exactly one cycle, the cycle after the eighth byte is accepted, on both match and mismatch. It stays 0 after each of the first seven bytes.
- R5: `cmd_en` rises one cycle after `brk_req`. While `cmd_en` is 1, `cmd_valid` equals `rx_valid` and `cmd_data` equals `rx_data`. Bytes received after the key phase do not change `unlocked`.
- R6: While locked, an address in [`PROT_LO`, `PROT_HI`] (default 16'h8000 to 16'hFFFD) gives `cpu_rdata` = 8'h00. Other addresses, and every address while unlocked, give `mem_rdata`.
- R7: `fetch_rst_req` is 1 in the same cycle as `bus_en` and `bus_fetch` to a protected address while locked. It is 0 when unlocked, outside the window, or for a data access.
- R8: While `rst_n` is low, `cmd_en` is 0 and `unlocked` is kept. One cycle after `rst_n` rises, `cmd_en` returns to 1 with no new break and no key entry.
- R9: A power-on reset clears `unlocked`. A new eight-byte key is then needed.
- R10: Bytes presented while `rst_n` is low are not counted as key bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | General reset, active low, asynchronous |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| key_bytes | input | 64 | Stored key, byte i at bits 8i+7:8i |
| bus_en | input | 1 | Memory access in progress |
| bus_fetch | input | 1 | Access is an instruction fetch |
| bus_addr | input | 16 | Access address |
| mem_rdata | input | 8 | Data from the memory array |
| cpu_rdata | output | 8 | Data returned to the core, masked while locked |
| fetch_rst_req | output | 1 | Illegal-address reset request |
| brk_req | output | 1 | One-cycle break request to the transmitter |
| cmd_en | output | 1 | Command decoding enabled |
| cmd_valid | output | 1 | Byte strobe to the command decoder |
| cmd_data | output | 8 | Byte to the command decoder |
| unlocked | output | 1 | Security is bypassed |

## Verification
A wrong byte counter shows up first at `brk_req`. The pulse comes one cycle too early or too late relative to the eighth byte. The bench samples it after every byte, so the error is seen within that byte. A sticky error bit that is lost or never set shows in `unlocked` in the cycle after the eighth byte. It then shows in the masked read data and the fetch reset request straight after, which is why single mismatches at the first, a middle and the last position are driven, along with a reordered key. A reset path that clears the wrong state shows in the first cycle after release: `cmd_en` either fails to come back, or `unlocked` drops after a general reset.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
    localparam int BYTE_W  = 8;
    localparam int KEY_LEN = 8;
    localparam int KEY_W   = BYTE_W * KEY_LEN;
    localparam int CNT_W   = $clog2(KEY_LEN + 1);
    localparam int IDX_W   = $clog2(KEY_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
        logic             unlocked;
        logic             brk;
    } coll_state_t;
endpackage

// File: rtl/key_collector.sv
module key_collector
    import unlock_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              accept_en,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [KEY_W-1:0]  key_bytes,
    output logic              key_done,
    output logic              brk,
    output logic              unlocked
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_LEN - 1);
    localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(KEY_LEN);

    coll_state_t       s_d, s_q;
    logic [BYTE_W-1:0] key_arr [KEY_LEN];
    logic [BYTE_W-1:0] expect_byte;
    logic              mismatch;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign key_arr[g] = key_bytes[g*BYTE_W +: BYTE_W];
    end

    assign key_done    = (s_q.cnt == DONE_CNT);
    assign expect_byte = key_arr[s_q.cnt[IDX_W-1:0]];
    assign mismatch    = (rx_data != expect_byte);

    always_comb begin
        s_d     = s_q;
        s_d.brk = 1'b0;
        if (accept_en && rx_valid && !key_done) begin
            s_d.err = s_q.err | mismatch;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_IDX) begin
                s_d.brk      = 1'b1;
                s_d.unlocked = !(s_q.err | mismatch);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign brk      = s_q.brk;
    assign unlocked = s_q.unlocked;

    // R4
    brk_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        s_q.brk |=> !s_q.brk);
    // R9
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        s_q.unlocked |=> s_q.unlocked);
    // R2
    unlock_at_brk_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(s_q.unlocked) |-> s_q.brk);
    // R3
    brk_after_all_chk: assert property (@(posedge clk) disable iff (!por_n)
        s_q.brk |-> key_done);
endmodule

// File: rtl/access_gate.sv
module access_gate #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] PROT_LO     = 16'h8000,
    parameter logic [ADDR_W-1:0] PROT_HI     = 16'hFFFD,
    parameter logic [DATA_W-1:0] INVALID_VAL = '0
) (
    input  logic              unlocked,
    input  logic              bus_en,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              fetch_rst_req
);
    logic in_prot;
    logic blocked;

    always_comb begin
        in_prot       = (bus_addr >= PROT_LO) && (bus_addr <= PROT_HI);
        blocked       = in_prot && !unlocked;
        cpu_rdata     = blocked ? INVALID_VAL : mem_rdata;
        fetch_rst_req = blocked && bus_en && bus_fetch;
    end
endmodule

// File: rtl/sec_unlock_ctrl.sv
module sec_unlock_ctrl
    import unlock_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PROT_LO     = 16'h8000,
    parameter logic [ADDR_W-1:0] PROT_HI     = 16'hFFFD,
    parameter logic [BYTE_W-1:0] INVALID_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [KEY_W-1:0]  key_bytes,
    input  logic              bus_en,
    input  logic              bus_fetch,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              fetch_rst_req,
    output logic              brk_req,
    output logic              cmd_en,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              unlocked
);
    logic sys_n;
    logic key_done;
    logic cmd_en_d, cmd_en_q;

    assign sys_n = por_n & rst_n;

    key_collector u_coll (
        .clk       (clk),
        .por_n     (por_n),
        .accept_en (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .key_bytes (key_bytes),
        .key_done  (key_done),
        .brk       (brk_req),
        .unlocked  (unlocked)
    );

    access_gate #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (BYTE_W),
        .PROT_LO     (PROT_LO),
        .PROT_HI     (PROT_HI),
        .INVALID_VAL (INVALID_VAL)
    ) u_gate (
        .unlocked      (unlocked),
        .bus_en        (bus_en),
        .bus_fetch     (bus_fetch),
        .bus_addr      (bus_addr),
        .mem_rdata     (mem_rdata),
        .cpu_rdata     (cpu_rdata),
        .fetch_rst_req (fetch_rst_req)
    );

    always_comb begin
        cmd_en_d = key_done;
    end

    always_ff @(posedge clk or negedge sys_n) begin
        if (!sys_n) cmd_en_q <= 1'b0;
        else        cmd_en_q <= cmd_en_d;
    end

    assign cmd_en    = cmd_en_q;
    assign cmd_valid = rx_valid && cmd_en_q;
    assign cmd_data  = rx_data;

    // R7
    fetch_lock_chk: assert property (@(posedge clk) disable iff (!sys_n)
        fetch_rst_req |-> !unlocked);
    // R5
    cmd_after_brk_chk: assert property (@(posedge clk) disable iff (!sys_n)
        brk_req |-> !cmd_en_q);
    // R5
    cmd_src_chk: assert property (@(posedge clk) disable iff (!sys_n)
        $rose(cmd_en_q) |-> key_done);
endmodule

// File: tb/sec_unlock_ctrl_tb.sv
module sec_unlock_ctrl_tb;
    localparam logic [63:0] KEY = 64'h8877_6655_4433_2211;
    localparam int NV = 5;
    // {byte stream (byte i at bits 8i+7:8i), expected unlock}
    localparam logic [64:0] VECS [NV] = '{
        {KEY, 1'b1},
        {KEY ^ 64'h0000_0000_0000_0001, 1'b0},
        {KEY ^ 64'h0000_0000_FF00_0000, 1'b0},
        {KEY ^ 64'h8000_0000_0000_0000, 1'b0},
        {64'h1122_3344_5566_7788, 1'b0}
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        bus_en = 1'b0, bus_fetch = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  mem_rdata = 8'hA5;
    logic [7:0]  cpu_rdata, cmd_data;
    logic        fetch_rst_req, brk_req, cmd_en, cmd_valid, unlocked;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;

    sec_unlock_ctrl u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .rx_valid(rx_valid),
        .rx_data(rx_data), .key_bytes(KEY), .bus_en(bus_en),
        .bus_fetch(bus_fetch), .bus_addr(bus_addr), .mem_rdata(mem_rdata),
        .cpu_rdata(cpu_rdata), .fetch_rst_req(fetch_rst_req),
        .brk_req(brk_req), .cmd_en(cmd_en), .cmd_valid(cmd_valid),
        .cmd_data(cmd_data), .unlocked(unlocked)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic por_pulse();
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    // drives one byte; returns at the falling edge after it was accepted
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic f, output logic [7:0] rd, output logic rq);
        bus_en = 1'b1; bus_addr = a; bus_fetch = f;
        #1; rd = cpu_rdata; rq = fetch_rst_req;
        bus_en = 1'b0; bus_fetch = 1'b0;
    endtask

    task automatic send_key(input logic [63:0] s, input logic exp);
        for (int i = 0; i < 8; i++) begin
            send_byte(s[8*i +: 8]);
            if (i < 7) begin
                check("R4 no early break", brk_req, 0);
                check("R3 no early decision", unlocked, 0);
            end
        end
        check("R4 break after eighth byte", brk_req, 1);
        check("R2/R3 unlock outcome", unlocked, exp);
        check("R5 cmd_en low during break", cmd_en, 0);
        @(negedge clk);
        check("R4 break is one cycle", brk_req, 0);
        check("R5 cmd_en after break", cmd_en, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       rq;
        // R1 reset state
        #1;
        check("R1 unlocked in POR", unlocked, 0);
        check("R1 brk in POR", brk_req, 0);
        check("R1 cmd_en in POR", cmd_en, 0);
        rx_valid = 1'b1; #1;
        check("R1 cmd_valid in POR", cmd_valid, 0);
        rx_valid = 1'b0;

        for (int v = 0; v < NV; v++) begin
            por_pulse();
            check("R1 unlocked after POR", unlocked, 0);
            check("R1 cmd_en after POR", cmd_en, 0);
            send_key(VECS[v][64:1], VECS[v][0]);
            probe(16'h9000, 1'b0, rd, rq);
            check("R6 protected read", rd, VECS[v][0] ? 8'hA5 : 8'h00);
            check("R7 no reset on data access", rq, 0);
            probe(16'h1000, 1'b0, rd, rq);
            check("R6 unprotected read", rd, 8'hA5);
            probe(16'h9000, 1'b1, rd, rq);
            check("R7 protected fetch", rq, !VECS[v][0]);
            probe(16'h1000, 1'b1, rd, rq);
            check("R7 unprotected fetch", rq, 0);
            probe(16'hFFFE, 1'b1, rd, rq);
            check("R7 fetch above window", rq, 0);
        end

        // unlock, then post-key bytes pass through (R5)
        por_pulse();
        send_key(KEY, 1'b1);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h3C; #1;
        check("R5 cmd_valid pass", cmd_valid, 1);
        check("R5 cmd_data pass", cmd_data, 8'h3C);
        @(negedge clk); rx_valid = 1'b0; #1;
        check("R5 cmd_valid follows", cmd_valid, 0);
        check("R5 extra byte keeps unlock", unlocked, 1);
        check("R4 no break on extra byte", brk_req, 0);

        // general reset keeps unlock (R8), ignores bytes (R10)
        rst_n = 1'b0; #1;
        check("R8 cmd_en low in reset", cmd_en, 0);
        check("R8 unlock kept", unlocked, 1);
        rx_valid = 1'b1; rx_data = 8'h11; #1;
        check("R10 no cmd_valid in reset", cmd_valid, 0);
        @(negedge clk); rx_valid = 1'b0; rst_n = 1'b1; #1;
        check("R8 cmd_en not yet back", cmd_en, 0);
        @(negedge clk);
        check("R8 cmd_en back", cmd_en, 1);
        check("R8 no new break", brk_req, 0);
        check("R8 still unlocked", unlocked, 1);

        // POR relocks (R9)
        por_pulse();
        check("R9 POR relocks", unlocked, 0);
        probe(16'h9000, 1'b0, rd, rq);
        check("R9 read masked again", rd, 8'h00);

        // R10: byte in general reset is not counted
        rst_n = 1'b0;
        send_byte(8'h11);
        rst_n = 1'b1;
        send_key(KEY, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule